// File: doc/BRIEF.md
# Sixteen-bit Arithmetic/Logic Unit with Status Flags

This block computes a 16-bit result from two operands and an operation code in a single combinational path. It can add, subtract, increment, decrement, apply a bitwise AND, OR, XOR or complement, and shift left or right by one bit. A mode pin narrows the operation to the low byte.

Alongside the result, the block keeps a small status register. It holds carry, auxiliary (nibble) carry, parity, zero, sign and signed overflow. The register loads on a clock edge only when the flag-write pin is high and the operation code is one of the defined codes. A surrounding execution engine reads `result` in the same cycle it drives the operands. It sees the updated flags from the next cycle on. Increment and decrement read the stored carry back, so that they can keep it.

Top module: `alu16_flags`

## Requirements
- R1: Code 0 (add) gives A+B and code 1 (subtract) gives A−B, both modulo the active width. Carry is set on a carry out of the top active bit for add, and on a borrow (A < B unsigned) for subtract.
- R2: Code 2 (AND), code 3 (OR), code 4 (XOR) and code 7 (complement of A) produce the bitwise result. They clear carry, auxiliary carry and overflow.
- R3: Code 5 (increment) gives A+1 and code 6 (decrement) gives A−1. The carry flag keeps its stored value.
- R4: Auxiliary carry (flags bit 1) is set for add, subtract, increment and decrement when bit 3 produces a carry or a borrow into bit 4.
- R5: Parity (flags bit 2) is 1 when bits 7..0 of the result hold an even number of ones, and 0 otherwise, in both byte and word mode.
- R6: Zero (flags bit 3) is 1 when the result is zero. Sign (flags bit 4) copies the top active bit of the result.
- R7: With `byte_mode` high, only bits 7..0 of the operands are used and bits 15..8 of the result are zero. Carry, sign and overflow are then taken at bit 7.
- R8: Code 8 (shift left by one) puts the top active bit of A into carry. Code 9 (shift right by one, zero fill) puts bit 0 of A into carry. Both clear auxiliary carry and overflow.
- R9: Overflow (flags bit 5) is set for add, subtract, increment and decrement when the signed result at the active width is out of range.
- R10: The flags (carry at bit 0) load at a rising clock edge only when `flag_wr` is high and the code is 0..9. Codes 10..15 return A masked to the active width and never change the flags.
- R11: While `rst_n` is low, all six flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_code | input | 4 | Operation select, codes 0..9 defined |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| byte_mode | input | 1 | 1 = operate on the low byte only |
| flag_wr | input | 1 | Load the flags at the next rising edge |
| result | output | 16 | Combinational result |
| flags_q | output | 6 | Stored flags: {overflow, sign, zero, parity, aux, carry} |

## Verification
The only state inside the block is the flag register, so any fault there shows on `flags_q` one edge after the write that should have produced it. Faults in the carry path have a second way out. A wrong stored carry is read back by increment and decrement, so it survives those operations and stays visible on later cycles. A fault in the byte-mode masking or in the nibble and parity taps shows at once on `result`, or on the next edge through the parity and auxiliary bits. The bench runs every operation in both widths with a model that holds its own copy of the flags, and compares both outputs every cycle.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_NOT = 4'd7,
    OP_SHL = 4'd8,
    OP_SHR = 4'd9
  } alu_op_e;

  // packed MSB first: ovf is bit 5, cry is bit 0
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic par;
    logic aux;
    logic cry;
  } alu_flags_t;

  localparam int FLAG_W = $bits(alu_flags_t);

  function automatic logic op_defined(input logic [3:0] code);
    return code <= 4'(OP_SHR);
  endfunction

  function automatic logic op_is_arith(input logic [3:0] code);
    return (code == 4'(OP_ADD)) || (code == 4'(OP_SUB)) ||
           (code == 4'(OP_INC)) || (code == 4'(OP_DEC));
  endfunction

endpackage

// File: rtl/alu16_adder.sv
module alu16_adder
  import alu16_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [WIDTH-1:0] am,
  input  logic [WIDTH-1:0] bm,
  input  logic             byte_mode,
  input  logic [3:0]       op_code,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             aux_o,
  output logic             ovf_o
);
  localparam logic [WIDTH-1:0] ONE       = WIDTH'(1);
  localparam logic [WIDTH-1:0] BYTE_MASK = WIDTH'((1 << BYTE_W) - 1);

  logic             is_sub, is_step, sa, sb, sr;
  logic [WIDTH-1:0] rhs, mask;
  logic [WIDTH:0]   ext;
  logic [NIB_W:0]   nib;

  always_comb begin
    is_sub  = (op_code == 4'(OP_SUB)) || (op_code == 4'(OP_DEC));
    is_step = (op_code == 4'(OP_INC)) || (op_code == 4'(OP_DEC));
    mask    = byte_mode ? BYTE_MASK : '1;
    rhs     = is_step ? ONE : bm;
    ext     = is_sub ? ({1'b0, am} - {1'b0, rhs}) : ({1'b0, am} + {1'b0, rhs});
    nib     = is_sub ? ({1'b0, am[NIB_W-1:0]} - {1'b0, rhs[NIB_W-1:0]})
                     : ({1'b0, am[NIB_W-1:0]} + {1'b0, rhs[NIB_W-1:0]});
    sum_o   = ext[WIDTH-1:0] & mask;
    carry_o = byte_mode ? ext[BYTE_W] : ext[WIDTH];
    aux_o   = nib[NIB_W];
    sa      = byte_mode ? am[BYTE_W-1]    : am[WIDTH-1];
    sb      = byte_mode ? rhs[BYTE_W-1]   : rhs[WIDTH-1];
    sr      = byte_mode ? sum_o[BYTE_W-1] : sum_o[WIDTH-1];
    ovf_o   = is_sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
  end
endmodule

// File: rtl/alu16_logic_shift.sv
module alu16_logic_shift
  import alu16_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int BYTE_W = 8
) (
  input  logic [WIDTH-1:0] am,
  input  logic [WIDTH-1:0] bm,
  input  logic             byte_mode,
  input  logic [3:0]       op_code,
  output logic [WIDTH-1:0] res_o,
  output logic             shc_o
);
  localparam logic [WIDTH-1:0] BYTE_MASK = WIDTH'((1 << BYTE_W) - 1);

  logic [WIDTH-1:0] mask;

  always_comb begin
    mask  = byte_mode ? BYTE_MASK : '1;
    shc_o = 1'b0;
    case (op_code)
      4'(OP_AND): res_o = am & bm;
      4'(OP_OR):  res_o = am | bm;
      4'(OP_XOR): res_o = am ^ bm;
      4'(OP_NOT): res_o = ~am & mask;
      4'(OP_SHL): begin
        res_o = (am << 1) & mask;
        shc_o = byte_mode ? am[BYTE_W-1] : am[WIDTH-1];
      end
      4'(OP_SHR): begin
        res_o = am >> 1;
        shc_o = am[0];
      end
      default:    res_o = am;
    endcase
  end
endmodule

// File: rtl/alu16_flag_eval.sv
module alu16_flag_eval #(
  parameter int WIDTH  = 16,
  parameter int BYTE_W = 8
) (
  input  logic [WIDTH-1:0] res,
  input  logic             byte_mode,
  output logic             par_o,
  output logic             zro_o,
  output logic             sgn_o
);
  // parity over the low byte as an explicit xor chain
  logic [BYTE_W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < BYTE_W; i++) begin : g_par
    assign chain[i+1] = chain[i] ^ res[i];
  end

  assign par_o = ~chain[BYTE_W];
  assign zro_o = (res == '0);
  assign sgn_o = byte_mode ? res[BYTE_W-1] : res[WIDTH-1];
endmodule

// File: rtl/alu16_flag_reg.sv
module alu16_flag_reg
  import alu16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  alu_flags_t d,
  output alu_flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          op_code,
  input  logic [WIDTH-1:0]    opnd_a,
  input  logic [WIDTH-1:0]    opnd_b,
  input  logic                byte_mode,
  input  logic                flag_wr,
  output logic [WIDTH-1:0]    result,
  output logic [FLAG_W-1:0]   flags_q
);
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam logic [WIDTH-1:0] BYTE_MASK = WIDTH'((1 << BYTE_W) - 1);

  logic [WIDTH-1:0] mask, am, bm, add_res, lgc_res;
  logic             add_c, add_aux, add_ovf, sh_c, arith, step;
  logic             par, zro, sgn;
  alu_flags_t       nxt, cur;

  assign mask = byte_mode ? BYTE_MASK : '1;
  assign am   = opnd_a & mask;
  assign bm   = opnd_b & mask;

  alu16_adder #(.WIDTH(WIDTH), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_add (
    .am(am), .bm(bm), .byte_mode(byte_mode), .op_code(op_code),
    .sum_o(add_res), .carry_o(add_c), .aux_o(add_aux), .ovf_o(add_ovf)
  );

  alu16_logic_shift #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_lgc (
    .am(am), .bm(bm), .byte_mode(byte_mode), .op_code(op_code),
    .res_o(lgc_res), .shc_o(sh_c)
  );

  assign arith  = op_is_arith(op_code);
  assign step   = (op_code == 4'(OP_INC)) || (op_code == 4'(OP_DEC));
  assign result = arith ? add_res : lgc_res;

  alu16_flag_eval #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_eval (
    .res(result), .byte_mode(byte_mode),
    .par_o(par), .zro_o(zro), .sgn_o(sgn)
  );

  always_comb begin
    nxt.par = par;
    nxt.zro = zro;
    nxt.sgn = sgn;
    nxt.aux = arith & add_aux;
    nxt.ovf = arith & add_ovf;
    if (step)       nxt.cry = cur.cry;
    else if (arith) nxt.cry = add_c;
    else            nxt.cry = sh_c;
  end

  alu16_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n),
    .load(flag_wr && op_defined(op_code)),
    .d(nxt), .q(cur)
  );

  assign flags_q = cur;
endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_code,
  input logic              byte_mode,
  input logic              flag_wr,
  input logic [WIDTH-1:0]  result,
  input logic [FLAG_W-1:0] flags_q
);
  logic wr_ok, is_step, is_lgc;
  assign wr_ok   = flag_wr && (op_code <= 4'd9);
  assign is_step = (op_code == 4'd5) || (op_code == 4'd6);
  assign is_lgc  = (op_code == 4'd2) || (op_code == 4'd3) ||
                   (op_code == 4'd4) || (op_code == 4'd7);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(flags_q));

  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> flags_q[3] == ($past(result) == '0));

  assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> flags_q[2] == ~(^$past(result[7:0])));

  assert_byte_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> result[WIDTH-1:8] == '0);

  assert_keep_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && is_step) |=> flags_q[0] == $past(flags_q[0]));

  assert_logic_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && is_lgc) |=> (flags_q[0] == 1'b0) && (flags_q[1] == 1'b0) && (flags_q[5] == 1'b0));
endmodule

bind alu16_flags alu16_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .byte_mode(byte_mode),
  .flag_wr(flag_wr), .result(result), .flags_q(flags_q)
);

// File: tb/tb_alu16_flags.sv
`timescale 1ns/1ps
module tb_alu16_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_code = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic        byte_mode = 1'b0, flag_wr = 1'b0;
  logic [15:0] result;
  logic [5:0]  flags_q;

  int checks = 0, errors = 0;
  logic [5:0] mflags = '0;
  logic [5:0] pend_f = '0;
  bit         pend_wr = 0;
  string      last_tag = "R11";

  always #4 clk = ~clk;

  alu16_flags dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .byte_mode(byte_mode), .flag_wr(flag_wr), .result(result), .flags_q(flags_q)
  );

  always @(posedge clk) begin
    if (!rst_n) mflags <= '0;
    else if (pend_wr) mflags <= pend_f;
  end

  function automatic void ref_eval(input int op, input int a, input int b, input bit bm,
                                   input logic [5:0] fin, output int r, output logic [5:0] fo);
    int w, mask, ai, bi, sa, sb, sr;
    bit cf, af, of, pf, zf, sf;
    logic [7:0] lb;
    w = bm ? 8 : 16;
    mask = (1 << w) - 1;
    ai = a & mask; bi = b & mask;
    cf = 0; af = 0; of = 0;
    sa = (ai >> (w-1)) & 1; sb = (bi >> (w-1)) & 1;
    case (op)
      0: begin r = (ai + bi) & mask; cf = (ai + bi) > mask; af = ((ai & 15) + (bi & 15)) > 15;
               sr = (r >> (w-1)) & 1; of = (sa == sb) && (sr != sa); end
      1: begin r = (ai - bi) & mask; cf = ai < bi; af = (ai & 15) < (bi & 15);
               sr = (r >> (w-1)) & 1; of = (sa != sb) && (sr != sa); end
      2: r = ai & bi;
      3: r = ai | bi;
      4: r = ai ^ bi;
      5: begin r = (ai + 1) & mask; af = (ai & 15) == 15; cf = fin[0]; of = (r == (1 << (w-1))); end
      6: begin r = (ai - 1) & mask; af = (ai & 15) == 0;  cf = fin[0]; of = (ai == (1 << (w-1))); end
      7: r = (~ai) & mask;
      8: begin cf = sa; r = (ai << 1) & mask; end
      9: begin cf = ai & 1; r = ai >> 1; end
      default: begin r = ai; fo = fin; return; end
    endcase
    lb = r[7:0];
    pf = ~(^lb);
    zf = (r == 0);
    sf = (r >> (w-1)) & 1;
    fo = {of, sf, zf, pf, af, cf};
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0, 1:       return "R1";
      2, 3, 4, 7: return "R2";
      5, 6:       return "R3";
      8, 9:       return "R8";
      default:    return "R10";
    endcase
  endfunction

  task automatic check_flags();
    checks++;
    if (flags_q !== mflags) begin
      errors++;
      $display("FAIL %s flags actual=%b expected=%b", last_tag, flags_q, mflags);
    end
  endtask

  task automatic run_op(input int op, input int a, input int b, input bit bm, input bit wr, input string tag);
    int er;
    logic [5:0] ef;
    @(negedge clk);
    check_flags();
    op_code = op[3:0]; opnd_a = a[15:0]; opnd_b = b[15:0]; byte_mode = bm; flag_wr = wr;
    #1;
    ref_eval(op, a & 16'hFFFF, b & 16'hFFFF, bm, mflags, er, ef);
    checks++;
    if (result !== er[15:0]) begin
      errors++;
      $display("FAIL %s result op=%0d actual=%h expected=%h", tag, op, result, er[15:0]);
    end
    pend_f = ef;
    pend_wr = wr && (op <= 9);
    last_tag = tag;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (flags_q !== 6'b0) begin
      errors++;
      $display("FAIL R11 reset flags actual=%b expected=%b", flags_q, 6'b0);
    end
    rst_n = 1'b1;
    // directed corner cases
    run_op(0, 16'hFFFF, 16'h0001, 0, 1, "R4");   // wraps to zero, carry, aux
    run_op(5, 16'hFFFF, 0,        0, 1, "R3");   // carry kept at 1
    run_op(1, 16'h0000, 16'h0001, 0, 1, "R1");   // borrow, sign
    run_op(6, 16'h8000, 0,        0, 1, "R9");   // signed overflow on decrement
    run_op(0, 16'h7FFF, 16'h0001, 0, 1, "R9");
    run_op(2, 16'h0F00, 16'hFFFF, 0, 1, "R5");   // low byte zero -> parity 1
    run_op(3, 16'h0100, 16'h0000, 0, 1, "R5");
    run_op(4, 16'h1234, 16'h1234, 0, 1, "R6");
    run_op(0, 16'h12FF, 16'h3401, 1, 1, "R7");   // byte add -> 0, carry
    run_op(8, 16'h5580, 0,        1, 1, "R7");   // byte shift left carry from bit 7
    run_op(8, 16'h8001, 0,        0, 1, "R8");
    run_op(9, 16'h0001, 0,        0, 1, "R8");
    run_op(7, 16'h00FF, 0,        0, 1, "R2");
    run_op(0, 16'h0008, 16'h0008, 0, 0, "R10");  // no write: flags hold
    run_op(12, 16'hABCD, 16'h1111, 0, 1, "R10"); // undefined code: pass A
    run_op(14, 16'hABCD, 16'h1111, 1, 1, "R10");
    run_op(1, 16'h0010, 16'h0001, 1, 1, "R4");   // nibble borrow in byte mode
    run_op(5, 16'h7F7F, 0,        1, 1, "R6");
    // pseudo-random sweep
    for (int i = 0; i < 500; i++) begin
      int op;
      op = $urandom_range(0, 11);
      run_op(op, $urandom & 16'hFFFF, $urandom & 16'hFFFF, $urandom_range(0, 1),
             ($urandom_range(0, 3) != 0), tag_of(op));
    end
    @(negedge clk);
    check_flags();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule